// File: doc/BRIEF.md
# Double-Buffered Framebuffer Select Controller

This block arbitrates between two framebuffer memories, one of which is scanned out to the display while the other is drawn into. It holds the frame-select bit, which names the buffer on screen, and a pending request for the next frame-select value. It also decodes a small video control register that carries the display mode field and a priority bit. Drawing-side accesses are always steered to the buffer that is not on screen. The displayed buffer index is exported to the scan-out logic.

Software asks for a buffer swap by writing the frame-select register. A swap is only safe when the display is not fetching pixels, so a request takes effect at once during vertical blank or while the display is switched off. Otherwise it is parked and applied when the next vertical blank begins. A write to the mode byte that flips the priority bit emits a one-cycle palette-dirty pulse, so that downstream colour tables can be rebuilt.

Top module: `fbsel_ctrl`

## Requirements
- R1: After reset the displayed buffer is 0, the pending request is 0, the mode byte is 0 and `pal_dirty` is low.
- R2: A byte write to register offset 0xB records data bit 0 as the pending frame select and ignores data bits 7:1. While `vblank` is high, a value that differs from the current frame select replaces it at the same clock edge.
- R3: While `vblank` is low and the mode field (mode byte bits 1:0) is nonzero, a frame-select write leaves `disp_buf` unchanged.
- R4: While the mode field is zero, a frame-select write takes effect at once even with `vblank` low.
- R5: On the first cycle of a `vblank` high phase (a rising edge), a pending value that differs from the frame select is applied.
- R6: A drawing request drives exactly one bit of `fb_req`: bit index (frame select XOR 1). `fb_addr` carries `drw_addr` bits 16:0 unchanged.
- R7: A 16-bit write (`reg_wide` high) acts as a byte write of `reg_wdata[7:0]` to the odd byte of the addressed register: a word write to offset 0xA sets the frame select, and a word write to 0x0 sets the mode byte.
- R8: A mode-byte write (offset 0x1) that changes bit 7 (priority) pulses `pal_dirty` high for the one cycle after the write. A write that leaves bit 7 unchanged gives no pulse.
- R9: Reading offset 0x0 or 0x1 returns `{tv_std, 7'b0, mode byte}`. Bit 15 follows the `tv_std` input and no register write changes it.
- R10: Reading offset 0xA or 0xB returns `vblank` in bit 15 and the frame select in bit 0, with all other bits zero.
- R11: Byte writes to even offsets (0x0, 0xA) change neither the mode byte nor the frame select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 16-bit write, 0 = byte write |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| reg_rdata | output | 16 | Read data for the register at `reg_addr` |
| tv_std | input | 1 | Read-only video standard status bit |
| vblank | input | 1 | Vertical blank indicator |
| drw_req | input | 1 | Drawing-side access request |
| drw_addr | input | 17 | Drawing-side byte address within the window |
| fb_req | output | 2 | Per-buffer access enable, one bit per buffer |
| fb_addr | output | 17 | Address forwarded to the selected buffer |
| disp_buf | output | 1 | Index of the buffer being displayed |
| pal_dirty | output | 1 | One-cycle palette rebuild pulse |

## Verification
The bench builds the block with its default parameters: a 17-bit drawing window, a 2-bit mode field and the priority bit at position 7. Under these values the top address bit 16 and the highest priority bit position both pass through the routing and dirty-detect paths. Directed scenarios cover swaps requested inside and outside blanking, with the display on and off. They cover a parked request applied at the next blank edge, a word-wide write folded onto the odd byte, and byte writes to even offsets that must leave all state as it was.

// File: rtl/fbsel_pkg.sv
package fbsel_pkg;

  localparam int REG_AW = 4;

  typedef enum logic [2:0] {
    SLOT_MODE = 3'd0,
    SLOT_STAT = 3'd5
  } reg_slot_e;

  // A word access is folded onto the odd byte of the same register.
  function automatic logic [REG_AW-1:0] fn_norm_addr(input logic [REG_AW-1:0] a,
                                                     input logic wide);
    return wide ? (a | {{(REG_AW-1){1'b0}}, 1'b1}) : a;
  endfunction

  // A frame swap is safe while blanking or while the display is off.
  function automatic logic fn_swap_safe(input logic vb, input logic mode_nz);
    return vb | ~mode_nz;
  endfunction

  // The drawing side always targets the buffer that is not on screen.
  function automatic logic fn_draw_buf(input logic fs);
    return ~fs;
  endfunction

endpackage

// File: rtl/fbsel_regs.sv
module fbsel_regs
  import fbsel_pkg::*;
#(
  parameter int MODE_W  = 2,
  parameter int PRI_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [7:0]        mode_q,
  output logic              mode_nz,
  output logic              fs_wr,
  output logic              fs_bit,
  output logic              pal_dirty
);

  logic [REG_AW-1:0] eff_addr;
  logic              mode_wr;
  logic              pri_flip;

  assign eff_addr = fn_norm_addr(reg_addr, reg_wide);
  assign mode_wr  = reg_wr && (eff_addr == REG_AW'(4'h1));
  assign fs_wr    = reg_wr && (eff_addr == REG_AW'(4'hB));
  assign fs_bit   = reg_wdata[0];
  assign pri_flip = mode_wr && (reg_wdata[PRI_BIT] != mode_q[PRI_BIT]);
  assign mode_nz  = |mode_q[MODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      pal_dirty <= 1'b0;
    end else begin
      pal_dirty <= pri_flip;
      if (mode_wr) mode_q <= reg_wdata[7:0];
    end
  end

  // R8: a pulse only ever follows a mode write that moved the priority bit
  a_r8_dirty_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pal_dirty |-> ($past(mode_wr) && (mode_q[PRI_BIT] != $past(mode_q[PRI_BIT]))));

  // R11: the mode byte only moves on an odd-byte (or folded word) write
  a_r11_mode_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr[0] || reg_wide)) |=> $stable(mode_q));

endmodule

// File: rtl/fbsel_flip.sv
module fbsel_flip
  import fbsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  input  logic mode_nz,
  input  logic fs_wr,
  input  logic fs_bit,
  output logic fs_q,
  output logic pend_q
);

  logic vb_q;
  logic vb_rise;
  logic swap_now;
  logic swap_late;

  assign vb_rise   = vblank && !vb_q;
  assign swap_now  = fs_wr && fn_swap_safe(vblank, mode_nz) && (fs_bit != fs_q);
  assign swap_late = !fs_wr && vb_rise && (pend_q != fs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
      vb_q   <= 1'b0;
    end else begin
      vb_q <= vblank;
      if (fs_wr) pend_q <= fs_bit;
      if (swap_now)       fs_q <= fs_bit;
      else if (swap_late) fs_q <= pend_q;
    end
  end

  // R2: every frame-select write is recorded as the pending value
  a_r2_pend_record: assert property (@(posedge clk) disable iff (!rst_n)
    fs_wr |=> (pend_q == $past(fs_bit)));

  // R3: no swap while the display is fetching pixels
  a_r3_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank && mode_nz) |=> $stable(fs_q));

  // R5: the parked request lands on the blank edge
  a_r5_apply_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_rise && !fs_wr) |=> (fs_q == $past(pend_q)));

endmodule

// File: rtl/fbsel_route.sv
module fbsel_route
  import fbsel_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs,
  input  logic          drw_req,
  input  logic [AW-1:0] drw_addr,
  output logic [1:0]    fb_req,
  output logic [AW-1:0] fb_addr
);

  localparam int NBUF = 2;

  logic draw_idx;
  assign draw_idx = fn_draw_buf(fs);
  assign fb_addr  = drw_addr;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign fb_req[i] = drw_req && (draw_idx == 1'(i));
  end

  // R6: a request hits exactly one buffer and never the displayed one
  a_r6_route_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    drw_req |-> (($countones(fb_req) == 1) && !fb_req[fs]));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drw_req |-> (fb_req == 2'b00));

endmodule

// File: rtl/fbsel_ctrl.sv
module fbsel_ctrl
  import fbsel_pkg::*;
#(
  parameter int AW      = 17,
  parameter int MODE_W  = 2,
  parameter int PRI_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              tv_std,
  input  logic              vblank,
  input  logic              drw_req,
  input  logic [AW-1:0]     drw_addr,
  output logic [1:0]        fb_req,
  output logic [AW-1:0]     fb_addr,
  output logic              disp_buf,
  output logic              pal_dirty
);

  logic [7:0] mode_q;
  logic       mode_nz;
  logic       fs_wr;
  logic       fs_bit;
  logic       fs_q;
  logic       pend_q;

  fbsel_regs #(.MODE_W(MODE_W), .PRI_BIT(PRI_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mode_q(mode_q),
    .mode_nz(mode_nz), .fs_wr(fs_wr), .fs_bit(fs_bit), .pal_dirty(pal_dirty)
  );

  fbsel_flip u_flip (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .mode_nz(mode_nz),
    .fs_wr(fs_wr), .fs_bit(fs_bit), .fs_q(fs_q), .pend_q(pend_q)
  );

  fbsel_route #(.AW(AW)) u_route (
    .clk(clk), .rst_n(rst_n), .fs(fs_q), .drw_req(drw_req),
    .drw_addr(drw_addr), .fb_req(fb_req), .fb_addr(fb_addr)
  );

  assign disp_buf = fs_q;

  always_comb begin
    unique case (reg_slot_e'(reg_addr[REG_AW-1:1]))
      SLOT_MODE: reg_rdata = {tv_std, 7'b0, mode_q};
      SLOT_STAT: reg_rdata = {vblank, 14'b0, fs_q};
      default:   reg_rdata = 16'h0000;
    endcase
  end

  // R1: the block leaves reset showing buffer 0 with nothing parked
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!disp_buf && !pend_q && !pal_dirty));

  // R4: with the display off a differing write swaps at once
  a_r4_off_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_wr && !mode_nz) |=> (disp_buf == $past(fs_bit)));

endmodule

// File: tb/sim_fbsel_ctrl.sv
module sim_fbsel_ctrl;

  localparam int TCLK = 10;
  localparam int AW   = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_wide = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tv_std = 1'b1, vblank = 1'b0, drw_req = 1'b0;
  logic [AW-1:0] drw_addr = '0;
  logic [1:0]  fb_req;
  logic [AW-1:0] fb_addr;
  logic        disp_buf, pal_dirty;

  int n_chk = 0, n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  fbsel_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tv_std(tv_std), .vblank(vblank), .drw_req(drw_req), .drw_addr(drw_addr),
    .fb_req(fb_req), .fb_addr(fb_addr), .disp_buf(disp_buf), .pal_dirty(pal_dirty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write, returns at the next falling edge with the result visible
  task automatic wr(input logic wide, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_vb(input logic v);
    @(negedge clk); vblank = v; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 disp_buf", disp_buf, 0);
    chk("R1 pal_dirty", pal_dirty, 0);
    rd(4'h0, r); chk("R1 mode read", r, 16'h8000);
    rd(4'hA, r); chk("R1 status read", r, 16'h0000);
  endtask

  task automatic t_blank_flip;
    wr(0, 4'h1, 16'h0001);
    set_vb(1);
    wr(0, 4'hB, 16'h00FF);
    chk("R2 swap in blank", disp_buf, 1);
    wr(0, 4'hB, 16'h00FE);
    chk("R2 bit0 only", disp_buf, 0);
    set_vb(0);
  endtask

  task automatic t_hold_and_apply;
    wr(0, 4'hB, 16'h0001);
    chk("R3 held outside blank", disp_buf, 0);
    repeat (3) @(negedge clk);
    chk("R3 still held", disp_buf, 0);
    set_vb(1);
    chk("R5 applied at blank edge", disp_buf, 1);
    set_vb(0);
    wr(0, 4'hB, 16'h0000);
    chk("R3 held again", disp_buf, 1);
    set_vb(1);
    chk("R5 applied back", disp_buf, 0);
    set_vb(0);
  endtask

  task automatic t_mode_off;
    wr(0, 4'h1, 16'h0000);
    wr(0, 4'hB, 16'h0001);
    chk("R4 immediate when off", disp_buf, 1);
    wr(0, 4'hB, 16'h0000);
    chk("R4 immediate back", disp_buf, 0);
  endtask

  task automatic t_route;
    @(negedge clk);
    drw_req = 1'b1; drw_addr = 17'h1ABCD; #1;
    chk("R6 fb_req fs=0", fb_req, 2'b10);
    chk("R6 fb_addr", fb_addr, 17'h1ABCD);
    wr(0, 4'hB, 16'h0001);
    drw_addr = 17'h10001; #1;
    chk("R6 fb_req fs=1", fb_req, 2'b01);
    chk("R6 fb_addr top bit", fb_addr, 17'h10001);
    @(negedge clk); drw_req = 1'b0; #1;
    chk("R6 idle", fb_req, 2'b00);
    wr(0, 4'hB, 16'h0000);
  endtask

  task automatic t_word;
    logic [15:0] r;
    wr(1, 4'hA, 16'hFF01);
    chk("R7 word write to FS", disp_buf, 1);
    wr(1, 4'h0, 16'h5A03);
    rd(4'h0, r); chk("R7 word write to mode", r, 16'h8003);
    wr(0, 4'h1, 16'h0000);
    set_vb(1); wr(0, 4'hB, 16'h0000); set_vb(0);
  endtask

  task automatic t_dirty;
    wr(0, 4'h1, 16'h0081);
    chk("R8 pulse on prio change", pal_dirty, 1);
    @(negedge clk);
    chk("R8 single cycle", pal_dirty, 0);
    wr(0, 4'h1, 16'h0083);
    chk("R8 no pulse without change", pal_dirty, 0);
    wr(0, 4'h1, 16'h0002);
    chk("R8 pulse on clear", pal_dirty, 1);
    wr(0, 4'h1, 16'h0000);
  endtask

  task automatic t_read;
    logic [15:0] r;
    wr(0, 4'h1, 16'h00C2);
    rd(4'h1, r); chk("R9 mode read", r, 16'h80C2);
    tv_std = 1'b0;
    rd(4'h0, r); chk("R9 tv_std tracks input", r, 16'h00C2);
    wr(1, 4'h0, 16'hFFC2);
    rd(4'h0, r); chk("R9 bit15 not writable", r, 16'h00C2);
    tv_std = 1'b1;
    wr(0, 4'h1, 16'h0000);
    set_vb(1);
    rd(4'hB, r); chk("R10 status vblank", r, 16'h8000);
    wr(0, 4'hB, 16'h0001);
    rd(4'hA, r); chk("R10 status fs", r, 16'h8001);
    wr(0, 4'hB, 16'h0000);
    set_vb(0);
  endtask

  task automatic t_even_ignored;
    logic [15:0] r;
    wr(0, 4'h0, 16'h00FF);
    rd(4'h0, r); chk("R11 even mode byte", r, 16'h8000);
    chk("R11 no dirty", pal_dirty, 0);
    wr(0, 4'hA, 16'h0001);
    chk("R11 even fs byte", disp_buf, 0);
    set_vb(1);
    chk("R11 nothing parked", disp_buf, 0);
    set_vb(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_blank_flip();
    t_hold_and_apply();
    t_mode_off();
    t_route();
    t_word();
    t_dirty();
    t_read();
    t_even_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule